// File: doc/BRIEF.md
# Rename Dispatch Bandwidth Limiter

This block sits in the rename stage of an out-of-order core and decides, each cycle, how many of the waiting instructions of one thread may be renamed and passed to the back end. It looks at how many instructions are waiting and at the free space in the reorder buffer, issue queue, load queue and store queue. It also looks at the free physical register count of each register class, and at each slot's type and destination-register needs. From these it produces an accept mask over the rename slots, the number accepted and a request to hold the upstream stage.

The first limit is the smaller of the free reorder-buffer and issue-queue entries. Within that limit the slots are walked in order. Each load, store or atomic draws on its memory queue, and each slot draws on the register classes it writes, always against what remains after the earlier slots of the same cycle. The walk ends at the first slot that cannot be served. The block keeps two in-flight counters for loads and stores that have been sent but not yet included in the back end's free counts, and subtracts them from the queue counts it is given. It also counts each kind of stall event.

Top module: `rename_bw_limiter`

## Requirements
- R1: The number of accepted slots never exceeds the smaller of robFree and iqFree.
- R2: When instructions are waiting (availCount > 0) and that smaller value is 0, no slot is accepted and blockReq is 1.
- R3: When that smaller value is nonzero but below availCount, exactly that many slots are considered, and blockReq is 1.
- R4: A slot whose loadFlag is 1 and whose storeFlag and atomicFlag are both 0 needs one load-queue entry. The entries available are lqFree minus loadsInFlight (floored at 0), minus the loads accepted in lower slots this cycle. When none is left, acceptance stops at that slot, blockReq is 1 and lqFullEvents increments by 1 at the next edge.
- R5: A slot whose storeFlag or atomicFlag is 1 needs one store-queue entry, counted the same way from sqFree and storesInFlight. When none is left, acceptance stops at that slot, blockReq is 1 and sqFullEvents increments by 1.
- R6: slotDst holds, for slot s and class c, a DST_W-bit destination count at bit offset (s*NUM_CLS+c)*DST_W. regFree holds class c at bit offset c*CNT_W. A slot is served only if every class's count fits in what is left after the lower slots. Otherwise acceptance stops there, blockReq is 1 and regFullEvents increments by 1. For one slot, a missing queue entry takes priority over a register shortage as the recorded cause.
- R7: At each edge, loadsInFlight becomes its old value plus the loads accepted minus loadsReflected. storesInFlight follows the same rule with stores and atomics and storesReflected.
- R8: When R2 or R3 applies, robFullEvents increments if robFree <= iqFree, and iqFullEvents increments otherwise. No event counter increments in a cycle without blockReq, and none increments by more than 1.
- R9: acceptMask is always a contiguous run of ones from slot 0. No slot is accepted above a refused one, even if it needs no refused resource.
- R10: With availCount = 0, acceptMask is 0, blockReq is 0 and no counter changes.
- R11: After reset, both in-flight counters and all five event counters read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| availCount | input | CW | Number of waiting instructions, held in slots 0 upward |
| robFree | input | CNT_W | Free reorder-buffer entries |
| iqFree | input | CNT_W | Free issue-queue entries |
| lqFree | input | CNT_W | Free load-queue entries as reported by the back end |
| sqFree | input | CNT_W | Free store-queue entries as reported by the back end |
| loadsReflected | input | CNT_W | Loads the back end has now included in lqFree |
| storesReflected | input | CNT_W | Stores the back end has now included in sqFree |
| regFree | input | NUM_CLS*CNT_W | Free physical registers per class |
| slotIsLoad | input | WIDTH | Per-slot load flag |
| slotIsStore | input | WIDTH | Per-slot store flag |
| slotIsAtomic | input | WIDTH | Per-slot atomic flag |
| slotDst | input | WIDTH*NUM_CLS*DST_W | Per-slot, per-class destination register counts |
| acceptMask | output | WIDTH | Slots accepted this cycle |
| renamedCount | output | CW | Number of accepted slots |
| blockReq | output | 1 | Request to hold the upstream stage this cycle |
| loadsInFlight | output | CNT_W | Loads sent but not yet reflected |
| storesInFlight | output | CNT_W | Stores and atomics sent but not yet reflected |
| robFullEvents | output | EVT_W | Reorder-buffer limit events |
| iqFullEvents | output | EVT_W | Issue-queue limit events |
| lqFullEvents | output | EVT_W | Load-queue stop events |
| sqFullEvents | output | EVT_W | Store-queue stop events |
| regFullEvents | output | EVT_W | Physical-register stop events |

## Verification
The assertions assume that availCount never exceeds WIDTH. They also assume that the back end never reports more reflected loads or stores than are in flight plus those accepted in the same cycle, so the in-flight counters never wrap. The directed stimulus keeps to both assumptions: it drives availCount at most 4 and sets a reflected count only to drain counters it has itself filled on earlier steps. Queue and register counts are chosen so that each stop cause, the tie between the reorder buffer and the issue queue, and the floor-at-zero cases all occur without any counter running near its width.

// File: rtl/rdl_pkg.sv
package rdl_pkg;

  localparam int NUM_EVT = 5;

  typedef enum logic [1:0] {
    STOP_NONE = 2'd0,
    STOP_LQ   = 2'd1,
    STOP_SQ   = 2'd2,
    STOP_REG  = 2'd3
  } rdlStop_t;

  typedef struct packed {
    logic robFull;
    logic iqFull;
    logic lqFull;
    logic sqFull;
    logic regFull;
    logic block;
  } rdlStrobes_t;

endpackage

// File: rtl/rdl_limit_ctrl.sv
module rdl_limit_ctrl
  import rdl_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int CNT_W = 8,
  localparam int CW = $clog2(WIDTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CW-1:0]     availCount,
  input  logic [CNT_W-1:0]  robFree,
  input  logic [CNT_W-1:0]  iqFree,
  input  rdlStop_t          stopCause,
  output logic [CW-1:0]     cap,
  output rdlStrobes_t       strobes
);

  logic             robIsMin;
  logic [CNT_W-1:0] minFree;
  logic             busy;
  logic             limited;

  // ties go to the reorder buffer
  assign robIsMin = (robFree <= iqFree);
  assign minFree  = robIsMin ? robFree : iqFree;
  assign busy     = (availCount != '0);
  assign limited  = busy && (minFree < CNT_W'(availCount));
  assign cap      = limited ? minFree[CW-1:0] : availCount;

  always_comb begin
    strobes         = '0;
    strobes.robFull = limited && robIsMin;
    strobes.iqFull  = limited && !robIsMin;
    strobes.lqFull  = (stopCause == STOP_LQ);
    strobes.sqFull  = (stopCause == STOP_SQ);
    strobes.regFull = (stopCause == STOP_REG);
    strobes.block   = limited || (stopCause != STOP_NONE);
  end

  // R2: no space at all means nothing is considered and the stage holds
  assert_zero_space_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && robFree == '0) |-> (cap == '0 && strobes.block));

  // R10: nothing waiting means no hold request and no cap
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (availCount == '0) |-> (!strobes.block && cap == '0));

  // input range expected from the upstream stage
  assert_avail_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    CW'(availCount) <= CW'(WIDTH));

endmodule

// File: rtl/rdl_slot_chain.sv
module rdl_slot_chain
  import rdl_pkg::*;
#(
  parameter int WIDTH   = 4,
  parameter int NUM_CLS = 2,
  parameter int DST_W   = 2,
  parameter int CNT_W   = 8,
  localparam int CW = $clog2(WIDTH + 1)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [CW-1:0]                  cap,
  input  logic [CNT_W-1:0]               lqAvail,
  input  logic [CNT_W-1:0]               sqAvail,
  input  logic [NUM_CLS*CNT_W-1:0]       regFree,
  input  logic [WIDTH-1:0]               slotIsLoad,
  input  logic [WIDTH-1:0]               slotIsStore,
  input  logic [WIDTH-1:0]               slotIsAtomic,
  input  logic [WIDTH*NUM_CLS*DST_W-1:0] slotDst,
  output logic [WIDTH-1:0]               acceptMask,
  output logic [CW-1:0]                  acceptCount,
  output logic [CW-1:0]                  acceptLoads,
  output logic [CW-1:0]                  acceptStores,
  output rdlStop_t                       stopCause
);

  logic [WIDTH-1:0] needLq;
  logic [WIDTH-1:0] needSq;
  logic [CNT_W-1:0] dstNeed [WIDTH][NUM_CLS];

  for (genvar s = 0; s < WIDTH; s++) begin : gSlot
    assign needSq[s] = slotIsStore[s] | slotIsAtomic[s];
    assign needLq[s] = slotIsLoad[s] & ~needSq[s];
    for (genvar c = 0; c < NUM_CLS; c++) begin : gCls
      assign dstNeed[s][c] = CNT_W'(slotDst[(s*NUM_CLS+c)*DST_W +: DST_W]);
    end
  end

  logic [CNT_W-1:0] lqLeft;
  logic [CNT_W-1:0] sqLeft;
  logic [CNT_W-1:0] regLeft [NUM_CLS];
  logic             running;
  logic             regOk;

  always_comb begin
    acceptMask   = '0;
    acceptCount  = '0;
    acceptLoads  = '0;
    acceptStores = '0;
    stopCause    = STOP_NONE;
    running      = 1'b1;
    regOk        = 1'b1;
    lqLeft       = lqAvail;
    sqLeft       = sqAvail;
    for (int c = 0; c < NUM_CLS; c++) regLeft[c] = regFree[c*CNT_W +: CNT_W];
    for (int s = 0; s < WIDTH; s++) begin
      if (running && (CW'(s) < cap)) begin
        regOk = 1'b1;
        for (int c = 0; c < NUM_CLS; c++)
          if (dstNeed[s][c] > regLeft[c]) regOk = 1'b0;
        if (needLq[s] && lqLeft == '0) begin
          running   = 1'b0;
          stopCause = STOP_LQ;
        end else if (needSq[s] && sqLeft == '0) begin
          running   = 1'b0;
          stopCause = STOP_SQ;
        end else if (!regOk) begin
          running   = 1'b0;
          stopCause = STOP_REG;
        end else begin
          acceptMask[s] = 1'b1;
          acceptCount   = acceptCount + CW'(1);
          if (needLq[s]) begin
            lqLeft      = lqLeft - CNT_W'(1);
            acceptLoads = acceptLoads + CW'(1);
          end
          if (needSq[s]) begin
            sqLeft       = sqLeft - CNT_W'(1);
            acceptStores = acceptStores + CW'(1);
          end
          for (int c = 0; c < NUM_CLS; c++) regLeft[c] = regLeft[c] - dstNeed[s][c];
        end
      end
    end
  end

  // R9: accepted slots form a prefix from slot 0
  assert_prefix_R9: assert property (@(posedge clk) disable iff (!rstN)
    (acceptMask & (acceptMask + WIDTH'(1))) == '0);

  // R4: never more loads than load-queue entries available
  assert_lq_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    CNT_W'(acceptLoads) <= lqAvail);

  // R5: never more stores and atomics than store-queue entries available
  assert_sq_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    CNT_W'(acceptStores) <= sqAvail);

  // R6: a register stop leaves the refused slot and all above it empty
  assert_reg_stop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stopCause == STOP_REG) |-> (acceptCount < cap));

endmodule

// File: rtl/rdl_track.sv
module rdl_track
  import rdl_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int CNT_W = 8,
  parameter int EVT_W = 16,
  localparam int CW = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  rdlStrobes_t      strobes,
  input  logic [CW-1:0]    acceptLoads,
  input  logic [CW-1:0]    acceptStores,
  input  logic [CNT_W-1:0] lqFree,
  input  logic [CNT_W-1:0] sqFree,
  input  logic [CNT_W-1:0] loadsReflected,
  input  logic [CNT_W-1:0] storesReflected,
  output logic [CNT_W-1:0] lqAvail,
  output logic [CNT_W-1:0] sqAvail,
  output logic [CNT_W-1:0] loadsInFlight,
  output logic [CNT_W-1:0] storesInFlight,
  output logic [EVT_W-1:0] evtCnt [NUM_EVT]
);

  assign lqAvail = (lqFree > loadsInFlight) ? lqFree - loadsInFlight : '0;
  assign sqAvail = (sqFree > storesInFlight) ? sqFree - storesInFlight : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadsInFlight  <= '0;
      storesInFlight <= '0;
    end else begin
      loadsInFlight  <= loadsInFlight + CNT_W'(acceptLoads) - loadsReflected;
      storesInFlight <= storesInFlight + CNT_W'(acceptStores) - storesReflected;
    end
  end

  logic [NUM_EVT-1:0] evtHit;
  assign evtHit = {strobes.regFull, strobes.sqFull, strobes.lqFull,
                   strobes.iqFull, strobes.robFull};

  for (genvar e = 0; e < NUM_EVT; e++) begin : gEvt
    always_ff @(posedge clk) begin
      if (!rstN)          evtCnt[e] <= '0;
      else if (evtHit[e]) evtCnt[e] <= evtCnt[e] + EVT_W'(1);
    end

    // R8: an event counter moves only in a cycle that requested a hold
    assert_evt_needs_block_R8: assert property (@(posedge clk) disable iff (!rstN)
      !strobes.block |=> $stable(evtCnt[e]));
  end

  // R7: no accepted and no reflected loads leaves the load count alone
  assert_load_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (acceptLoads == '0 && loadsReflected == '0) |=> $stable(loadsInFlight));

  // R7: the back end reports no more than is outstanding
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    (loadsReflected <= loadsInFlight + CNT_W'(acceptLoads)) &&
    (storesReflected <= storesInFlight + CNT_W'(acceptStores)));

endmodule

// File: rtl/rename_bw_limiter.sv
module rename_bw_limiter
  import rdl_pkg::*;
#(
  parameter int WIDTH   = 4,
  parameter int NUM_CLS = 2,
  parameter int DST_W   = 2,
  parameter int CNT_W   = 8,
  parameter int EVT_W   = 16,
  localparam int CW = $clog2(WIDTH + 1)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [CW-1:0]                  availCount,
  input  logic [CNT_W-1:0]               robFree,
  input  logic [CNT_W-1:0]               iqFree,
  input  logic [CNT_W-1:0]               lqFree,
  input  logic [CNT_W-1:0]               sqFree,
  input  logic [CNT_W-1:0]               loadsReflected,
  input  logic [CNT_W-1:0]               storesReflected,
  input  logic [NUM_CLS*CNT_W-1:0]       regFree,
  input  logic [WIDTH-1:0]               slotIsLoad,
  input  logic [WIDTH-1:0]               slotIsStore,
  input  logic [WIDTH-1:0]               slotIsAtomic,
  input  logic [WIDTH*NUM_CLS*DST_W-1:0] slotDst,
  output logic [WIDTH-1:0]               acceptMask,
  output logic [CW-1:0]                  renamedCount,
  output logic                           blockReq,
  output logic [CNT_W-1:0]               loadsInFlight,
  output logic [CNT_W-1:0]               storesInFlight,
  output logic [EVT_W-1:0]               robFullEvents,
  output logic [EVT_W-1:0]               iqFullEvents,
  output logic [EVT_W-1:0]               lqFullEvents,
  output logic [EVT_W-1:0]               sqFullEvents,
  output logic [EVT_W-1:0]               regFullEvents
);

  logic [CW-1:0]    cap;
  rdlStrobes_t      strobes;
  rdlStop_t         stopCause;
  logic [CW-1:0]    acceptLoads;
  logic [CW-1:0]    acceptStores;
  logic [CNT_W-1:0] lqAvail;
  logic [CNT_W-1:0] sqAvail;
  logic [EVT_W-1:0] evtCnt [NUM_EVT];

  rdl_limit_ctrl #(.WIDTH(WIDTH), .CNT_W(CNT_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .availCount (availCount),
    .robFree    (robFree),
    .iqFree     (iqFree),
    .stopCause  (stopCause),
    .cap        (cap),
    .strobes    (strobes)
  );

  rdl_slot_chain #(
    .WIDTH(WIDTH), .NUM_CLS(NUM_CLS), .DST_W(DST_W), .CNT_W(CNT_W)
  ) uChain (
    .clk          (clk),
    .rstN         (rstN),
    .cap          (cap),
    .lqAvail      (lqAvail),
    .sqAvail      (sqAvail),
    .regFree      (regFree),
    .slotIsLoad   (slotIsLoad),
    .slotIsStore  (slotIsStore),
    .slotIsAtomic (slotIsAtomic),
    .slotDst      (slotDst),
    .acceptMask   (acceptMask),
    .acceptCount  (renamedCount),
    .acceptLoads  (acceptLoads),
    .acceptStores (acceptStores),
    .stopCause    (stopCause)
  );

  rdl_track #(.WIDTH(WIDTH), .CNT_W(CNT_W), .EVT_W(EVT_W)) uTrack (
    .clk             (clk),
    .rstN            (rstN),
    .strobes         (strobes),
    .acceptLoads     (acceptLoads),
    .acceptStores    (acceptStores),
    .lqFree          (lqFree),
    .sqFree          (sqFree),
    .loadsReflected  (loadsReflected),
    .storesReflected (storesReflected),
    .lqAvail         (lqAvail),
    .sqAvail         (sqAvail),
    .loadsInFlight   (loadsInFlight),
    .storesInFlight  (storesInFlight),
    .evtCnt          (evtCnt)
  );

  assign blockReq      = strobes.block;
  assign robFullEvents = evtCnt[0];
  assign iqFullEvents  = evtCnt[1];
  assign lqFullEvents  = evtCnt[2];
  assign sqFullEvents  = evtCnt[3];
  assign regFullEvents = evtCnt[4];

  // R1: accepted count bounded by both reorder-buffer and issue-queue space
  assert_cap_R1: assert property (@(posedge clk) disable iff (!rstN)
    (CNT_W'(renamedCount) <= robFree) && (CNT_W'(renamedCount) <= iqFree));

  // R3: accepting fewer than are waiting always comes with a hold request
  assert_cut_block_R3: assert property (@(posedge clk) disable iff (!rstN)
    (renamedCount < availCount) |-> blockReq);

  // R9: mask population matches the reported count
  assert_count_match_R9: assert property (@(posedge clk) disable iff (!rstN)
    $countones(acceptMask) == int'(renamedCount));

endmodule

// File: tb/rename_bw_limiter_test.sv
`timescale 1ns/1ps
module rename_bw_limiter_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic [2:0]  availCount;
  logic [7:0]  robFree, iqFree, lqFree, sqFree;
  logic [7:0]  loadsReflected, storesReflected;
  logic [15:0] regFree;
  logic [3:0]  slotIsLoad, slotIsStore, slotIsAtomic;
  logic [15:0] slotDst;
  logic [3:0]  acceptMask;
  logic [2:0]  renamedCount;
  logic        blockReq;
  logic [7:0]  loadsInFlight, storesInFlight;
  logic [15:0] robFullEvents, iqFullEvents, lqFullEvents, sqFullEvents, regFullEvents;

  int checks = 0;
  int fails  = 0;
  int eRob = 0, eIq = 0, eLq = 0, eSq = 0, eReg = 0, eLif = 0, eSif = 0;

  always #2.5 clk = ~clk;

  rename_bw_limiter uut (
    .clk(clk), .rstN(rstN), .availCount(availCount),
    .robFree(robFree), .iqFree(iqFree), .lqFree(lqFree), .sqFree(sqFree),
    .loadsReflected(loadsReflected), .storesReflected(storesReflected),
    .regFree(regFree), .slotIsLoad(slotIsLoad), .slotIsStore(slotIsStore),
    .slotIsAtomic(slotIsAtomic), .slotDst(slotDst),
    .acceptMask(acceptMask), .renamedCount(renamedCount), .blockReq(blockReq),
    .loadsInFlight(loadsInFlight), .storesInFlight(storesInFlight),
    .robFullEvents(robFullEvents), .iqFullEvents(iqFullEvents),
    .lqFullEvents(lqFullEvents), .sqFullEvents(sqFullEvents),
    .regFullEvents(regFullEvents)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setIdle();
    availCount = 3'd0;
    robFree = 8'd50; iqFree = 8'd50; lqFree = 8'd50; sqFree = 8'd50;
    loadsReflected = 8'd0; storesReflected = 8'd0;
    regFree = {8'd50, 8'd50};
    slotIsLoad = '0; slotIsStore = '0; slotIsAtomic = '0;
    slotDst = '0;
  endtask

  function automatic logic [15:0] dstField(input logic [15:0] base, input int s,
                                           input int c, input int v);
    logic [15:0] r = base;
    r[(s*2+c)*2 +: 2] = v[1:0];
    return r;
  endfunction

  // check the combinational result of the current inputs
  task automatic checkNow(input string tag, input int mask, input int blk);
    #1;
    check({tag, " mask"}, int'(acceptMask), mask);
    check({tag, " count"}, int'(renamedCount), $countones(mask[3:0]));
    check({tag, " block"}, int'(blockReq), blk);
  endtask

  // clock the step in and compare every counter with the expected totals
  task automatic checkAfter(input string tag);
    @(posedge clk); #1;
    check({tag, " robEv R8"}, int'(robFullEvents), eRob);
    check({tag, " iqEv R8"},  int'(iqFullEvents),  eIq);
    check({tag, " lqEv R4"},  int'(lqFullEvents),  eLq);
    check({tag, " sqEv R5"},  int'(sqFullEvents),  eSq);
    check({tag, " regEv R6"}, int'(regFullEvents), eReg);
    check({tag, " loads R7"}, int'(loadsInFlight), eLif);
    check({tag, " stores R7"}, int'(storesInFlight), eSif);
    @(negedge clk);
    setIdle();
  endtask

  task automatic testReset();
    check("R11 robEv", int'(robFullEvents), 0);
    check("R11 iqEv", int'(iqFullEvents), 0);
    check("R11 lqEv", int'(lqFullEvents), 0);
    check("R11 sqEv", int'(sqFullEvents), 0);
    check("R11 regEv", int'(regFullEvents), 0);
    check("R11 loads", int'(loadsInFlight), 0);
    check("R11 stores", int'(storesInFlight), 0);
  endtask

  task automatic testPlenty();
    availCount = 3'd4;
    checkNow("R1 plenty", 4'b1111, 0);
    checkAfter("R1 plenty");
    availCount = 3'd3; robFree = 8'd3; iqFree = 8'd3;
    checkNow("R1 exact fit", 4'b0111, 0);
    checkAfter("R1 exact fit");
  endtask

  task automatic testRobIqCap();
    availCount = 3'd4; robFree = 8'd2; iqFree = 8'd5;
    checkNow("R3 rob cut", 4'b0011, 1);
    eRob++;
    checkAfter("R3 rob cut");
    availCount = 3'd3; robFree = 8'd5; iqFree = 8'd1;
    checkNow("R3 iq cut", 4'b0001, 1);
    eIq++;
    checkAfter("R3 iq cut");
    availCount = 3'd3; robFree = 8'd2; iqFree = 8'd2;
    checkNow("R8 tie", 4'b0011, 1);
    eRob++;
    checkAfter("R8 tie");
  endtask

  task automatic testZeroSpace();
    availCount = 3'd2; robFree = 8'd0; iqFree = 8'd9;
    checkNow("R2 rob zero", 4'b0000, 1);
    eRob++;
    checkAfter("R2 rob zero");
    availCount = 3'd0; robFree = 8'd0; iqFree = 8'd0;
    checkNow("R10 idle", 4'b0000, 0);
    checkAfter("R10 idle");
  endtask

  task automatic testLoads();
    availCount = 3'd4; slotIsLoad = 4'b1111; lqFree = 8'd2;
    checkNow("R4 lq short", 4'b0011, 1);
    eLq++; eLif = 2;
    checkAfter("R4 lq short");
    availCount = 3'd4; slotIsLoad = 4'b1111; lqFree = 8'd3;
    checkNow("R4 in-flight deducted", 4'b0001, 1);
    eLq++; eLif = 3;
    checkAfter("R4 in-flight deducted");
    loadsReflected = 8'd3;
    checkNow("R7 reflect", 4'b0000, 0);
    eLif = 0;
    checkAfter("R7 reflect");
    availCount = 3'd2; slotIsLoad = 4'b0011; lqFree = 8'd2;
    checkNow("R4 lq exact", 4'b0011, 0);
    eLif = 2;
    checkAfter("R4 lq exact");
    availCount = 3'd1; slotIsLoad = 4'b0001; lqFree = 8'd1;
    checkNow("R4 lq floor zero", 4'b0000, 1);
    eLq++;
    checkAfter("R4 lq floor zero");
    loadsReflected = 8'd2;
    eLif = 0;
    checkAfter("R7 reflect 2");
  endtask

  task automatic testStores();
    availCount = 3'd4; slotIsStore = 4'b0101; slotIsAtomic = 4'b0010; sqFree = 8'd2;
    checkNow("R5 sq short", 4'b0011, 1);
    eSq++; eSif = 2;
    checkAfter("R5 sq short");
    storesReflected = 8'd2;
    eSif = 0;
    checkAfter("R7 store reflect");
    availCount = 3'd1; slotIsLoad = 4'b0001; sqFree = 8'd0; lqFree = 8'd5;
    checkNow("R5 load ignores sq", 4'b0001, 0);
    eLif = 1;
    checkAfter("R5 load ignores sq");
    loadsReflected = 8'd1;
    eLif = 0;
    checkAfter("R7 reflect 1");
  endtask

  task automatic testPrefix();
    availCount = 3'd4; slotIsLoad = 4'b0011; lqFree = 8'd1;
    checkNow("R9 prefix", 4'b0001, 1);
    eLq++; eLif = 1;
    checkAfter("R9 prefix");
    loadsReflected = 8'd1;
    eLif = 0;
    checkAfter("R9 drain");
    availCount = 3'd4; slotIsLoad = 4'b1001; slotIsStore = 4'b0010; lqFree = 8'd1;
    checkNow("R9 mixed", 4'b0111, 1);
    eLq++; eLif = 1; eSif = 1;
    checkAfter("R9 mixed");
    loadsReflected = 8'd1; storesReflected = 8'd1;
    eLif = 0; eSif = 0;
    checkAfter("R9 mixed drain");
  endtask

  task automatic testRegs();
    logic [15:0] d;
    availCount = 3'd4; regFree = {8'd50, 8'd3};
    d = dstField('0, 0, 0, 2); d = dstField(d, 1, 0, 2); slotDst = d;
    checkNow("R6 class0 short", 4'b0001, 1);
    eReg++;
    checkAfter("R6 class0 short");
    availCount = 3'd4; regFree = {8'd1, 8'd9};
    d = dstField('0, 1, 1, 1); d = dstField(d, 2, 1, 1); slotDst = d;
    checkNow("R6 class1 short", 4'b0011, 1);
    eReg++;
    checkAfter("R6 class1 short");
    availCount = 3'd4; regFree = {8'd0, 8'd4};
    d = dstField('0, 0, 0, 2); d = dstField(d, 1, 0, 2); slotDst = d;
    checkNow("R6 exact regs", 4'b1111, 0);
    checkAfter("R6 exact regs");
    availCount = 3'd1; regFree = {8'd50, 8'd1}; lqFree = 8'd0; slotIsLoad = 4'b0001;
    slotDst = dstField('0, 0, 0, 3);
    checkNow("R6 queue before regs", 4'b0000, 1);
    eLq++;
    checkAfter("R6 queue before regs");
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    setIdle();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    testReset();
    testPlenty();
    testRobIqCap();
    testZeroSpace();
    testLoads();
    testStores();
    testPrefix();
    testRegs();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule